// File: doc/BRIEF.md
# I/O Bus Port Address Decoder

This block sits between the I/O side of an 8-bit microprocessor bus and a board carrying up to four parallel ports. Each port has two sections. On every system clock the block samples the I/O address, the input and output status strobes, the data-in and write strobes, and the wait acknowledge. The upper address bits are compared with a strapped board number. A hit counts only while an input or output status is active. A selected transfer produces one-hot port chip-selects, a register select, a read/write line and a merged enable strobe. It also produces an enable for the read data path back toward the processor.

On an input transfer the block holds the processor for one wait state. This gives the ports time to settle their address setup before data is read. Output transfers run with no wait. The system reset doubles as the power-on clear: it clears the wait logic and is passed to the ports as their reset.

Top module: `io_port_decoder`

## Requirements
- R1: The board is hit only when sampled address bits [7:4] equal the 4-bit `board_strap` exactly. Any other value leaves every chip-select low and `data_oe` low.
- R2: A hit selects the board only while the sampled `stat_in` or `stat_out` is high. With both low, all `port_cs` bits and `data_oe` stay low.
- R3: While selected, `port_cs` is one-hot and follows address bits [3:2]: value k drives bit k. When not selected, `port_cs` is all zero.
- R4: `reg_sel` equals sampled address bits [1:0]. The codes are 0 = section A control, 1 = section A data, 2 = section B control, 3 = section B data.
- R5: `port_en` is high when the sampled data-in strobe or the sampled write strobe is high.
- R6: `port_rw_n` is low (write) exactly when the sampled `stat_out` is high, and high (read) otherwise.
- R7: A wait latch sets on the clock after a sample in which `stat_in` has just risen (low in the previous sample, high now) while the address hits. It clears on the clock after a sample with `wait_ack` high. When clear and set coincide, clear wins. Each rise of `stat_in` sets the latch at most once.
- R8: `ready` is low only while the wait latch is set and the board is selected. Output-only cycles never set the latch.
- R9: While `rst_n` is low at a clock edge, all sampled inputs and the wait latch clear. `port_rst_n` follows `rst_n`.
- R10: `data_oe` is high exactly when the board is selected and both the sampled `stat_in` and the sampled data-in strobe are high.
- R11: All outputs come from inputs registered on the previous rising clock edge. An input change shows at the outputs after exactly one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset and power-on clear |
| io_addr | input | 8 | I/O device address |
| board_strap | input | 4 | Strapped board number |
| stat_in | input | 1 | Input-cycle status |
| stat_out | input | 1 | Output-cycle status |
| dbin_stb | input | 1 | Data-in strobe |
| wr_stb | input | 1 | Write strobe |
| wait_ack | input | 1 | Wait acknowledge from processor |
| port_cs | output | 4 | One-hot port chip-selects |
| reg_sel | output | 2 | Register select within the port |
| port_rw_n | output | 1 | Port read (1) / write (0) |
| port_en | output | 1 | Merged enable strobe |
| ready | output | 1 | Ready to processor, low holds a wait |
| data_oe | output | 1 | Read data path enable toward the processor |
| port_rst_n | output | 1 | Active-low reset to the ports |

## Verification
The wait latch can be told to set and to clear in the same clock. This happens when a fresh rise of the input status arrives together with a high wait acknowledge. The bench provokes it with a directed vector and again many times in random traffic. Its reference model gives clear the priority and judges `ready` on the following cycle. A second overlap is a new input cycle that starts while an earlier wait is still pending. The model tracks the latch state so that `ready` is compared on every clock.

// File: rtl/io_dec_pkg.sv
// Package: shared types for the I/O port address decoder.
// Assumes one sampling clock for every bus input.
package io_dec_pkg;

    // Register-select codes seen by a port
    typedef enum logic [1:0] {
        RSEL_A_CTL  = 2'd0,
        RSEL_A_DATA = 2'd1,
        RSEL_B_CTL  = 2'd2,
        RSEL_B_DATA = 2'd3
    } rsel_e;

    // Sampled bus status and strobes
    typedef struct packed {
        logic st_in;
        logic st_out;
        logic dbin;
        logic wr;
        logic wack;
    } bus_status_t;

endpackage

// File: rtl/board_match.sv
// Module: board_match
// Compares the board field of the sampled address with the strap and
// qualifies the hit with the I/O status. Purely combinational.
// Assumes the address and status are already registered.
module board_match #(
    parameter int ADDR_W   = 8,
    parameter int LOW_BITS = 4,
    localparam int BOARD_W = ADDR_W - LOW_BITS
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BOARD_W-1:0] strap,
    input  io_dec_pkg::bus_status_t st,
    output logic               hit,
    output logic               sel
);
    // Exact compare of the board field, then status qualification
    always_comb begin
        hit = (addr[ADDR_W-1:LOW_BITS] == strap);
        sel = hit && (st.st_in || st.st_out);
    end
endmodule

// File: rtl/port_select.sv
// Module: port_select
// Decodes the port field into one-hot chip-selects and passes the
// register field through. Chip-selects are gated by board selection.
module port_select #(
    parameter int ADDR_W    = 8,
    parameter int PORT_BITS = 2,
    parameter int REG_BITS  = 2,
    localparam int NPORTS   = 1 << PORT_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                sel,
    output logic [NPORTS-1:0]   port_cs,
    output logic [REG_BITS-1:0] reg_sel
);
    logic [PORT_BITS-1:0] port_fld;

    // Extract the port field above the register field
    always_comb port_fld = addr[REG_BITS +: PORT_BITS];

    // One comparator per port
    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_cs
        always_comb port_cs[gi] = sel && (port_fld == PORT_BITS'(gi));
    end

    // Register field goes straight to the ports
    always_comb reg_sel = addr[REG_BITS-1:0];
endmodule

// File: rtl/wait_gen.sv
// Module: wait_gen
// One-shot wait latch. It sets after a rising input status on a hit
// and clears on wait acknowledge; clear dominates. Synchronous
// active-low reset. Assumes the inputs are sampled registers.
module wait_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic st_in,
    input  logic st_out,
    input  logic hit,
    input  logic wack,
    output logic wait_q
);
    logic st_in_d;

    // Previous input-status sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) st_in_d <= 1'b0;
        else        st_in_d <= st_in;
    end

    // Wait latch: clear has priority over set
    always_ff @(posedge clk) begin
        if (!rst_n)                        wait_q <= 1'b0;
        else if (wack)                     wait_q <= 1'b0;
        else if (st_in && !st_in_d && hit) wait_q <= 1'b1;
    end

    assert_wait_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wack |=> !wait_q);

    assert_wait_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_q) |-> $past(st_in && hit));

    assert_out_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_q && !st_in && st_out) |=> !wait_q);
endmodule

// File: rtl/io_port_decoder.sv
// Module: io_port_decoder (top)
// Samples the I/O bus on one clock and produces the port selects,
// the strobes, the ready signal and the read data path enable.
// Assumes board_strap is static during operation.
module io_port_decoder #(
    parameter int ADDR_W    = 8,
    parameter int PORT_BITS = 2,
    parameter int REG_BITS  = 2,
    localparam int LOW_BITS = PORT_BITS + REG_BITS,
    localparam int BOARD_W  = ADDR_W - LOW_BITS,
    localparam int NPORTS   = 1 << PORT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [BOARD_W-1:0]  board_strap,
    input  logic                stat_in,
    input  logic                stat_out,
    input  logic                dbin_stb,
    input  logic                wr_stb,
    input  logic                wait_ack,
    output logic [NPORTS-1:0]   port_cs,
    output logic [REG_BITS-1:0] reg_sel,
    output logic                port_rw_n,
    output logic                port_en,
    output logic                ready,
    output logic                data_oe,
    output logic                port_rst_n
);
    import io_dec_pkg::*;

    logic [ADDR_W-1:0] addr_s;
    bus_status_t       st_s;
    logic              hit;
    logic              sel;
    logic              wait_q;

    // Sample every bus input on the system clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_s <= '0;
            st_s   <= '0;
        end else begin
            addr_s <= io_addr;
            st_s   <= '{st_in: stat_in, st_out: stat_out, dbin: dbin_stb,
                        wr: wr_stb, wack: wait_ack};
        end
    end

    board_match #(.ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS)) u_match (
        .addr (addr_s),
        .strap(board_strap),
        .st   (st_s),
        .hit  (hit),
        .sel  (sel)
    );

    port_select #(.ADDR_W(ADDR_W), .PORT_BITS(PORT_BITS), .REG_BITS(REG_BITS)) u_psel (
        .addr   (addr_s),
        .sel    (sel),
        .port_cs(port_cs),
        .reg_sel(reg_sel)
    );

    wait_gen u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .st_in (st_s.st_in),
        .st_out(st_s.st_out),
        .hit   (hit),
        .wack  (st_s.wack),
        .wait_q(wait_q)
    );

    // Strobes, direction, ready and read data path enable
    always_comb begin
        port_en    = st_s.dbin || st_s.wr;
        port_rw_n  = !st_s.st_out;
        ready      = !(wait_q && sel);
        data_oe    = sel && st_s.st_in && st_s.dbin;
        port_rst_n = rst_n;
    end

    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_cs));

    assert_cs_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_cs) |-> (st_s.st_in || st_s.st_out));

    assert_ready_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (|port_cs));
endmodule

// File: tb/io_port_decoder_tb.sv
`timescale 1ns/1ps
module io_port_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic [3:0] board_strap = 4'h2;
    logic       stat_in = 0, stat_out = 0, dbin_stb = 0, wr_stb = 0, wait_ack = 0;
    logic [3:0] port_cs;
    logic [1:0] reg_sel;
    logic       port_rw_n, port_en, ready, data_oe, port_rst_n;

    io_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .board_strap(board_strap),
        .stat_in(stat_in), .stat_out(stat_out), .dbin_stb(dbin_stb),
        .wr_stb(wr_stb), .wait_ack(wait_ack), .port_cs(port_cs),
        .reg_sel(reg_sel), .port_rw_n(port_rw_n), .port_en(port_en),
        .ready(ready), .data_oe(data_oe), .port_rst_n(port_rst_n)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference model state, updated on each rising edge
    logic [7:0] m_addr = '0;
    bit m_in = 0, m_out = 0, m_dbin = 0, m_wr = 0, m_wack = 0, m_in_prev = 0, m_wait = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = '0; m_in = 0; m_out = 0; m_dbin = 0; m_wr = 0; m_wack = 0;
            m_in_prev = 0; m_wait = 0;
        end else begin
            if (m_wack) m_wait = 0;
            else if (m_in && !m_in_prev && (m_addr[7:4] == board_strap)) m_wait = 1;
            m_in_prev = m_in;
            m_addr = io_addr; m_in = stat_in; m_out = stat_out;
            m_dbin = dbin_stb; m_wr = wr_stb; m_wack = wait_ack;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic check_all();
        bit sel;
        int exp_cs;
        sel = (m_addr[7:4] == board_strap) && (m_in || m_out);
        exp_cs = sel ? (1 << m_addr[3:2]) : 0;
        chk("R1/R2/R3 port_cs", port_cs, exp_cs);
        chk("R4 reg_sel", reg_sel, m_addr[1:0]);
        chk("R6 port_rw_n", port_rw_n, !m_out);
        chk("R5 port_en", port_en, m_dbin || m_wr);
        chk("R7/R8 ready", ready, !(m_wait && sel));
        chk("R10 data_oe", data_oe, sel && m_in && m_dbin);
        chk("R9 port_rst_n", port_rst_n, rst_n);
    endtask

    // Check the previous vector's effect, then apply the next one (R11)
    task automatic step(input logic [7:0] a, input bit i, input bit o,
                        input bit d, input bit w, input bit k);
        @(negedge clk);
        check_all();
        io_addr = a; stat_in = i; stat_out = o; dbin_stb = d; wr_stb = w; wait_ack = k;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R9: reset state, with bus activity held off by reset
        step(8'h25, 1, 0, 1, 0, 0);
        step(8'h25, 1, 0, 1, 0, 0);
        @(negedge clk); rst_n = 1;
        io_addr = 0; stat_in = 0; dbin_stb = 0;
        // R1/R3/R4/R6: output cycles to every port and register, no wait (R8)
        for (int p = 0; p < 16; p++) begin
            step({4'h2, p[3:0]}, 0, 1, 0, 0, 0);
            step({4'h2, p[3:0]}, 0, 1, 0, 1, 0);
            step({4'h2, p[3:0]}, 0, 0, 0, 0, 0);
        end
        // R1: strap mismatch, R2: hit without status
        step(8'h35, 1, 0, 1, 0, 0);
        step(8'h35, 0, 0, 0, 0, 0);
        step(8'h29, 0, 0, 1, 0, 0);
        step(8'h29, 0, 0, 0, 1, 0);
        // R7/R10: input cycle with one wait, then acknowledge
        step(8'h26, 1, 0, 0, 0, 0);
        step(8'h26, 1, 0, 0, 0, 0);
        step(8'h26, 1, 0, 0, 0, 0);
        step(8'h26, 1, 0, 0, 0, 1);
        step(8'h26, 1, 0, 1, 0, 0);
        step(8'h26, 1, 0, 1, 0, 0);
        step(8'h26, 0, 0, 0, 0, 0);
        // R7: set and clear coincide, clear wins
        step(8'h2B, 1, 0, 0, 0, 1);
        step(8'h2B, 1, 0, 1, 0, 0);
        step(8'h2B, 1, 0, 1, 0, 0);
        step(8'h2B, 0, 0, 0, 0, 0);
        // R8: wait pending and still pending when output status shows up
        step(8'h21, 1, 0, 0, 0, 0);
        step(8'h21, 0, 1, 0, 1, 0);
        step(8'h21, 0, 1, 0, 1, 0);
        step(8'h21, 0, 0, 0, 0, 1);
        step(8'h21, 0, 0, 0, 0, 0);
        // Random traffic, board field biased toward a hit
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            a = 8'($urandom);
            if ($urandom_range(0, 3) != 0) a[7:4] = board_strap;
            step(a, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
                 1'($urandom), 1'($urandom), 1'($urandom_range(0, 4) == 0));
            if (n == 2000) board_strap = 4'hC;
        end
        // R9: reset mid-run clears a pending wait
        step(8'hC4, 1, 0, 0, 0, 0);
        step(8'hC4, 1, 0, 0, 0, 0);
        @(negedge clk); check_all(); rst_n = 0;
        step(8'hC4, 1, 0, 0, 0, 0);
        step(8'hC4, 1, 0, 0, 0, 0);
        @(negedge clk); check_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule